// File: doc/BRIEF.md
# Host-to-Serial Video Memory Bridge

This block sits between an 8-bit host register page and a serial memory that holds an overlay picture. The host writes the memory through the bridge. In bit mode, one register write clocks one data bit into the memory. In byte mode, one register write loads a shifter that clocks out eight bits on its own. Software supplies every opcode, address byte and data byte of a write transaction, and it opens and closes chip select through a control register.

For display, the bridge sends a read command once per frame. The command is the read opcode followed by a start address that software can reload between frames. After the command, the bridge turns every pixel-rate enable into one serial clock pulse and one captured picture bit.

Host access is allowed only while the blanking flag is high. Any strobe that arrives during the active window changes nothing except a sticky flag.

Top module: `vram_serial_bridge`

## Requirements
- R1: After reset, `mem_cs_n` is high and `mem_sck`, `mem_mosi`, `busy`, `pix_valid` and `blocked` are low.
- R2: A blanking-time write to offset 2 with bit 0 set opens a transaction, and `mem_cs_n` goes low from the next cycle on. A write to offset 2 with bit 0 clear, made while a transaction is open, closes it, and `mem_cs_n` goes high from the next cycle on.
- R3: In an open transaction, a write to offset 0 gives one cycle with `mem_mosi` equal to data bit 7 and `mem_sck` low. The next cycle keeps the same `mem_mosi` with `mem_sck` high. After that, `mem_sck` and `mem_mosi` return low.
- R4: In an open transaction, a write to offset 1 sends the 8 data bits MSB first. Each bit takes two cycles, the first with `mem_sck` low and the second with it high. `busy` is high for exactly those 16 cycles.
- R5: While `busy` is high, host strobes to any offset are ignored: the serial waveform goes on unchanged and the transaction state does not change.
- R6: Writes to offsets 0 and 1 while no transaction is open leave `mem_cs_n` high and `mem_sck` low.
- R7: A strobe made while `vblank` is low has no effect on the serial pins or on any register. It sets `blocked` from the next cycle on. `blocked` stays set until an accepted write to offset 2 clears it.
- R8: Offsets 3 and 4 hold the low and high bytes of the read start address. When the bridge is idle, stream enable (offset 2 bit 1) is set and `vblank` is low, a `frame_go` pulse lowers `mem_cs_n`. The bridge then sends opcode 0x03 followed by the 16-bit address, MSB first, at two cycles per bit with `mem_sck` low and then high.
- R9: After the command, each cycle in which `pix_en` is high produces, in the next cycle, one cycle of `mem_sck` high and `pix_valid` high. In that cycle `pix_bit` equals `mem_miso` as it was in the `pix_en` cycle. Cycles without `pix_en` give `mem_sck` and `pix_valid` low.
- R10: When `vblank` rises during the stream, `mem_cs_n` goes high in the next cycle.
- R11: `frame_go` is ignored while stream enable is clear, while `vblank` is high, or while a write transaction is open.
- R12: The read start address is taken fresh at each `frame_go`, so a new address written during blanking is used by the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register page write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host data bus |
| vblank | input | 1 | High while the display is in its blank lines |
| frame_go | input | 1 | Once-per-frame start pulse for the display read |
| pix_en | input | 1 | Pixel-rate enable during the stream |
| mem_miso | input | 1 | Serial data from the memory |
| mem_sck | output | 1 | Serial clock to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_mosi | output | 1 | Serial data to the memory |
| pix_bit | output | 1 | Captured picture bit |
| pix_valid | output | 1 | `pix_bit` is new in this cycle |
| busy | output | 1 | Write shifter is clocking bits out |
| blocked | output | 1 | Sticky flag for a strobe refused during the active window |

## Verification
The bench drives single-bit writes with both polarities of bit 7, and bytes with alternating and mixed patterns. These separate MSB-first ordering from other orderings, and they show whether the clock phases line up with the data. It sends strobes in the middle of a byte, strobes without an open transaction, and strobes during the active window. These show that each refusal path leaves the waveform alone, and that only the active-window case raises the flag. Two frames use different start addresses, and each carries a mixed pixel bit pattern. This tells a per-frame address reload apart from a stale one, and it shows that each captured bit is paired with its own clock pulse. Start pulses sent with the stream disabled, during blanking, or with a write open check that the read cannot begin in any of those conditions.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    localparam int HOST_DW = 8;
    localparam int REG_AW  = 3;

    // register page offsets
    localparam logic [REG_AW-1:0] OFF_BIT   = 3'd0;
    localparam logic [REG_AW-1:0] OFF_BYTE  = 3'd1;
    localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd2;
    localparam logic [REG_AW-1:0] OFF_RA_LO = 3'd3;
    localparam logic [REG_AW-1:0] OFF_RA_HI = 3'd4;

    // control register fields
    localparam int CTRL_OPEN_BIT   = 0;
    localparam int CTRL_STREAM_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_SH_LO,
        ST_SH_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_STREAM
    } vsb_state_e;

endpackage

// File: rtl/vsb_host_regs.sv
module vsb_host_regs
    import vsb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [REG_AW-1:0]        host_addr,
    input  logic [HOST_DW-1:0]       host_wdata,
    input  logic                     vblank,
    input  logic                     hold,
    output logic                     ev_bit,
    output logic                     ev_byte,
    output logic                     ev_ctrl,
    output logic                     stream_en,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     blocked
);

    localparam int HI_W = ADDR_W - HOST_DW;

    logic               accept;
    logic [HOST_DW-1:0] ra_lo_q;
    logic [HI_W-1:0]    ra_hi_q;
    logic               stream_en_q;
    logic               blocked_q;

    // strobes count only in blanking and while no shift is running
    assign accept  = host_we && vblank && !hold;
    assign ev_bit  = accept && (host_addr == OFF_BIT);
    assign ev_byte = accept && (host_addr == OFF_BYTE);
    assign ev_ctrl = accept && (host_addr == OFF_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_lo_q     <= '0;
            ra_hi_q     <= '0;
            stream_en_q <= 1'b0;
        end else if (accept) begin
            if (host_addr == OFF_CTRL)  stream_en_q <= host_wdata[CTRL_STREAM_BIT];
            if (host_addr == OFF_RA_LO) ra_lo_q     <= host_wdata;
            if (host_addr == OFF_RA_HI) ra_hi_q     <= host_wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  blocked_q <= 1'b0;
        else if (host_we && !vblank) blocked_q <= 1'b1;
        else if (ev_ctrl)            blocked_q <= 1'b0;
    end

    assign stream_en = stream_en_q;
    assign rd_addr   = {ra_hi_q, ra_lo_q};
    assign blocked   = blocked_q;

endmodule

// File: rtl/vsb_serial_fsm.sv
module vsb_serial_fsm
    import vsb_pkg::*;
#(
    parameter int               ADDR_W     = 16,
    parameter int               CMD_W      = 8,
    parameter logic [CMD_W-1:0] RD_OPCODE  = 8'h03
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_bit,
    input  logic                ev_byte,
    input  logic                ev_ctrl,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic                frame_go,
    input  logic                stream_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                vblank,
    output logic                cs_n,
    output logic                sck_shift,
    output logic                mosi,
    output logic                busy,
    output logic                streaming
);

    localparam int TX_W  = CMD_W + ADDR_W;
    localparam int CNT_W = $clog2(TX_W + 1);

    vsb_state_e        state_q, state_d;
    logic [TX_W-1:0]   tx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_bit;
    logic              start_rd;
    logic              ctrl_open;

    assign last_bit  = (cnt_q == CNT_W'(1));
    assign start_rd  = frame_go && stream_en && !vblank;
    assign ctrl_open = host_wdata[CTRL_OPEN_BIT];

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_ctrl && ctrl_open) state_d = ST_OPEN;
                else if (start_rd)        state_d = ST_RD_LO;
            end
            ST_OPEN: begin
                if (ev_ctrl && !ctrl_open)  state_d = ST_IDLE;
                else if (ev_bit || ev_byte) state_d = ST_SH_LO;
            end
            ST_SH_LO:  state_d = ST_SH_HI;
            ST_SH_HI:  state_d = last_bit ? ST_OPEN : ST_SH_LO;
            ST_RD_LO:  state_d = vblank ? ST_IDLE : ST_RD_HI;
            ST_RD_HI: begin
                if (vblank)        state_d = ST_IDLE;
                else if (last_bit) state_d = ST_STREAM;
                else               state_d = ST_RD_LO;
            end
            ST_STREAM: state_d = vblank ? ST_IDLE : ST_STREAM;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shared transmit shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_rd && !ev_ctrl) begin
                        tx_q  <= {RD_OPCODE, rd_addr};
                        cnt_q <= CNT_W'(TX_W);
                    end
                end
                ST_OPEN: begin
                    if (ev_bit) begin
                        tx_q  <= {host_wdata[HOST_DW-1], {(TX_W-1){1'b0}}};
                        cnt_q <= CNT_W'(1);
                    end else if (ev_byte) begin
                        tx_q  <= {host_wdata, {(TX_W-HOST_DW){1'b0}}};
                        cnt_q <= CNT_W'(HOST_DW);
                    end
                end
                ST_SH_HI: begin
                    tx_q  <= tx_q << 1;
                    cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_RD_LO: begin
                    if (vblank) tx_q <= '0;
                end
                ST_RD_HI: begin
                    if (vblank) begin
                        tx_q <= '0;
                    end else begin
                        tx_q  <= tx_q << 1;
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        cs_n      = (state_q == ST_IDLE);
        sck_shift = (state_q == ST_SH_HI) || (state_q == ST_RD_HI);
        busy      = (state_q == ST_SH_LO) || (state_q == ST_SH_HI);
        streaming = (state_q == ST_STREAM);
        mosi      = tx_q[TX_W-1];
    end

endmodule

// File: rtl/vsb_pixel_capture.sv
module vsb_pixel_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic streaming,
    input  logic vblank,
    input  logic pix_en,
    input  logic mem_miso,
    output logic pix_bit,
    output logic pix_valid
);

    logic take;
    assign take = streaming && !vblank && pix_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_bit   <= 1'b0;
            pix_valid <= 1'b0;
        end else begin
            pix_valid <= take;
            if (take) pix_bit <= mem_miso;
        end
    end

endmodule

// File: rtl/vram_serial_bridge.sv
module vram_serial_bridge
    import vsb_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               CMD_W     = 8,
    parameter logic [CMD_W-1:0] RD_OPCODE = 8'h03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [REG_AW-1:0]  host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               vblank,
    input  logic               frame_go,
    input  logic               pix_en,
    input  logic               mem_miso,
    output logic               mem_sck,
    output logic               mem_cs_n,
    output logic               mem_mosi,
    output logic               pix_bit,
    output logic               pix_valid,
    output logic               busy,
    output logic               blocked
);

    logic              ev_bit, ev_byte, ev_ctrl;
    logic              stream_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              sck_shift;
    logic              streaming;

    vsb_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .vblank     (vblank),
        .hold       (busy),
        .ev_bit     (ev_bit),
        .ev_byte    (ev_byte),
        .ev_ctrl    (ev_ctrl),
        .stream_en  (stream_en),
        .rd_addr    (rd_addr),
        .blocked    (blocked)
    );

    vsb_serial_fsm #(
        .ADDR_W    (ADDR_W),
        .CMD_W     (CMD_W),
        .RD_OPCODE (RD_OPCODE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_bit     (ev_bit),
        .ev_byte    (ev_byte),
        .ev_ctrl    (ev_ctrl),
        .host_wdata (host_wdata),
        .frame_go   (frame_go),
        .stream_en  (stream_en),
        .rd_addr    (rd_addr),
        .vblank     (vblank),
        .cs_n       (mem_cs_n),
        .sck_shift  (sck_shift),
        .mosi       (mem_mosi),
        .busy       (busy),
        .streaming  (streaming)
    );

    vsb_pixel_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .streaming (streaming),
        .vblank    (vblank),
        .pix_en    (pix_en),
        .mem_miso  (mem_miso),
        .pix_bit   (pix_bit),
        .pix_valid (pix_valid)
    );

    // the capture strobe doubles as the stream clock pulse
    assign mem_sck = sck_shift | pix_valid;

endmodule

// File: rtl/vsb_checker.sv
module vsb_checker (
    input logic clk,
    input logic rst_n,
    input logic host_we,
    input logic vblank,
    input logic pix_en,
    input logic mem_sck,
    input logic mem_cs_n,
    input logic busy,
    input logic pix_valid,
    input logic blocked
);

    // R1: deselected memory never sees a clock edge
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> !mem_sck);

    // R3: a shift begins with the clock low
    assert_shift_starts_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mem_sck);

    // R4: shifting only happens with the memory selected
    assert_busy_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_cs_n);

    // R4: each high clock phase of a shift lasts one cycle
    assert_busy_sck_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_sck) |=> !mem_sck);

    // R7: a refused strobe raises the flag
    assert_refused_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !vblank) |=> blocked);

    // R7: the flag only falls on a host write
    assert_blocked_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !host_we) |=> blocked);

    // R9: every captured bit follows a pixel enable
    assert_pixel_follows_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_en));

endmodule

bind vram_serial_bridge vsb_checker u_vsb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .vblank    (vblank),
    .pix_en    (pix_en),
    .mem_sck   (mem_sck),
    .mem_cs_n  (mem_cs_n),
    .busy      (busy),
    .pix_valid (pix_valid),
    .blocked   (blocked)
);

// File: tb/vram_serial_bridge_bench.sv
`timescale 1ns/1ps
module vram_serial_bridge_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       vblank = 1'b1;
    logic       frame_go = 1'b0;
    logic       pix_en = 1'b0;
    logic       mem_miso = 1'b0;
    logic       mem_sck, mem_cs_n, mem_mosi, pix_bit, pix_valid, busy, blocked;

    always #2 clk = ~clk;

    vram_serial_bridge u_vram_serial_bridge (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .vblank(vblank), .frame_go(frame_go),
        .pix_en(pix_en), .mem_miso(mem_miso), .mem_sck(mem_sck),
        .mem_cs_n(mem_cs_n), .mem_mosi(mem_mosi), .pix_bit(pix_bit),
        .pix_valid(pix_valid), .busy(busy), .blocked(blocked)
    );

    // expected pin values for one cycle
    typedef struct packed {
        logic       cs_n;
        logic       sck;
        logic       mosi;
        logic       busy;
        logic       valid;
        logic       pbit;
        logic [1:0] kind;   // 0 idle/open, 1 shift, 2 command, 3 stream
        logic [3:0] req;
    } exp_t;

    exp_t   exp_q[$];
    exp_t   last_e;
    int     tests = 0;
    int     fails = 0;
    bit     done = 1'b0;
    bit     m_open = 1'b0;
    bit     m_stream = 1'b0;
    bit     m_stream_en = 1'b0;
    bit     m_blocked = 1'b0;
    logic [15:0] m_ra = '0;
    int     rest_req = 1;

    function automatic exp_t rest_e();
        exp_t e;
        e.cs_n  = !(m_open || m_stream);
        e.sck   = 1'b0;
        e.mosi  = 1'b0;
        e.busy  = 1'b0;
        e.valid = 1'b0;
        e.pbit  = 1'b0;
        e.kind  = m_stream ? 2'd3 : 2'd0;
        e.req   = 4'(rest_req);
        return e;
    endfunction

    function automatic exp_t mk(logic cs_n, logic sck, logic mosi, logic bsy,
                                logic vld, logic pb, logic [1:0] kind, int req);
        exp_t e;
        e.cs_n = cs_n; e.sck = sck; e.mosi = mosi; e.busy = bsy;
        e.valid = vld; e.pbit = pb; e.kind = kind; e.req = 4'(req);
        return e;
    endfunction

    // one clock: wait for the edge, then compare just after it
    task automatic tick();
        exp_t e;
        @(posedge clk);
        #1;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : rest_e();
        tests++;
        if (mem_cs_n !== e.cs_n || mem_sck !== e.sck || mem_mosi !== e.mosi ||
            busy !== e.busy || pix_valid !== e.valid ||
            (e.valid && pix_bit !== e.pbit)) begin
            fails++;
            $display("FAIL R%0d at %0t: cs_n,sck,mosi,busy,valid,bit actual=%b%b%b%b%b%b expected=%b%b%b%b%b%b",
                     e.req, $time, mem_cs_n, mem_sck, mem_mosi, busy, pix_valid, pix_bit,
                     e.cs_n, e.sck, e.mosi, e.busy, e.valid, e.pbit);
        end
        tests++;
        if (blocked !== m_blocked) begin
            fails++;
            $display("FAIL R7 at %0t: blocked actual=%b expected=%b", $time, blocked, m_blocked);
        end
        last_e = e;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic drain();
        while (exp_q.size() > 0) tick();
    endtask

    task automatic host_wr(logic [2:0] a, logic [7:0] d, int req);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        rest_req = req;
        if (!vblank) begin
            m_blocked = 1'b1;                         // R7 refused in active window
        end else if (!last_e.busy) begin              // R5 ignored while shifting
            case (a)
                3'd0: if (m_open) begin               // R3 single bit
                    exp_q.push_back(mk(0, 0, d[7], 1, 0, 0, 2'd1, req));
                    exp_q.push_back(mk(0, 1, d[7], 1, 0, 0, 2'd1, req));
                end
                3'd1: if (m_open) begin               // R4 whole byte
                    for (int i = 7; i >= 0; i--) begin
                        exp_q.push_back(mk(0, 0, d[i], 1, 0, 0, 2'd1, req));
                        exp_q.push_back(mk(0, 1, d[i], 1, 0, 0, 2'd1, req));
                    end
                end
                3'd2: begin                           // R2 open/close
                    m_stream_en = d[1];
                    m_blocked   = 1'b0;
                    if (m_open && !d[0])      m_open = 1'b0;
                    else if (!m_open && d[0] && last_e.cs_n) m_open = 1'b1;
                end
                3'd3: m_ra[7:0]  = d;
                3'd4: m_ra[15:8] = d;
                default: ;
            endcase
        end
        tick();
        host_we = 1'b0;
    endtask

    task automatic go_frame(int req);
        logic [23:0] cmd;
        frame_go = 1'b1;
        rest_req = req;
        if (last_e.cs_n && exp_q.size() == 0 && m_stream_en && !vblank) begin
            cmd = {8'h03, m_ra};                      // R8 opcode then address
            for (int i = 23; i >= 0; i--) begin
                exp_q.push_back(mk(0, 0, cmd[i], 0, 0, 0, 2'd2, 8));
                exp_q.push_back(mk(0, 1, cmd[i], 0, 0, 0, 2'd2, 8));
            end
            m_stream = 1'b1;
        end
        tick();
        frame_go = 1'b0;
    endtask

    task automatic pixel(logic b);
        pix_en = 1'b1; mem_miso = b;
        rest_req = 9;
        if (last_e.kind == 2'd3 && exp_q.size() == 0)
            exp_q.push_back(mk(0, 1, 0, 0, 1, b, 2'd3, 9));   // R9
        tick();
        pix_en = 1'b0;
        tick();
    endtask

    task automatic end_frame();
        vblank = 1'b1;
        rest_req = 10;
        m_stream = 1'b0;                              // R10 deselect next cycle
        tick();
    endtask

    initial begin
        logic [11:0] pat_a = 12'b1011_0010_1110;
        logic [11:0] pat_b = 12'b0100_1101_0011;
        last_e = '0;
        last_e.cs_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rest_req = 1;
        run(3);

        // R2 open a transaction
        host_wr(3'd2, 8'h01, 2);
        run(2);

        // R3 single bits, both polarities
        host_wr(3'd0, 8'h80, 3); drain(); run(2);
        host_wr(3'd0, 8'h7F, 3); drain(); run(1);

        // R4 byte, then R5 strobes during the shift
        host_wr(3'd1, 8'hA5, 4);
        run(2);
        host_wr(3'd1, 8'hFF, 5);
        host_wr(3'd2, 8'h00, 5);
        host_wr(3'd0, 8'h80, 5);
        drain(); run(2);
        host_wr(3'd1, 8'h3C, 4); drain(); run(1);

        // R2 close
        host_wr(3'd2, 8'h00, 2);
        run(2);

        // R6 data writes with nothing open
        host_wr(3'd0, 8'h80, 6); run(2);
        host_wr(3'd1, 8'hFF, 6); run(2);

        // R8 start address and stream enable
        host_wr(3'd3, 8'h34, 8);
        host_wr(3'd4, 8'h12, 8);
        host_wr(3'd2, 8'h02, 8);

        // R11 start pulse during blanking is ignored
        go_frame(11); run(2);

        // R7 refused strobe in the active window
        vblank = 1'b0; rest_req = 7; tick();
        host_wr(3'd1, 8'h55, 7);
        host_wr(3'd3, 8'h99, 7);              // must not change the start address
        run(1);

        // R8 command, R9 stream
        go_frame(8); drain(); tick();
        for (int i = 11; i >= 0; i--) pixel(pat_a[i]);
        end_frame(); run(2);                  // R10

        // R7 clear by accepted control write
        host_wr(3'd2, 8'h02, 7); run(1);

        // R12 new address for the next frame
        host_wr(3'd3, 8'hCD, 12);
        host_wr(3'd4, 8'hAB, 12);
        vblank = 1'b0; rest_req = 12; tick();
        go_frame(12); drain(); tick();
        for (int i = 11; i >= 0; i--) pixel(pat_b[i]);
        end_frame(); run(2);

        // R11 stream disabled
        host_wr(3'd2, 8'h00, 11);
        vblank = 1'b0; tick();
        go_frame(11); run(3);
        vblank = 1'b1; tick();

        // R11 write transaction open
        host_wr(3'd2, 8'h03, 11);
        vblank = 1'b0; tick();
        go_frame(11); run(3);
        vblank = 1'b1; tick();
        host_wr(3'd2, 8'h02, 2); run(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule